// File: doc/BRIEF.md
# Partitioned Packed SIMD Adder

This block adds two 64-bit operands that are split into independent packed lanes. A lane-size control chooses eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Every lane is summed in the same operation, and no carry crosses a lane boundary. A second control chooses per-lane behaviour on overflow: the lane either wraps modulo its width, or clamps to its all-ones value as unsigned saturating arithmetic. Saturating arithmetic of this kind is common in pixel and audio processing.

The adder is built from byte-wide segments. The carry between two neighbouring segments is cut at run time wherever a lane boundary falls. The sum and an 8-bit overflow flag vector are registered once. A valid strobe travels alongside the data with the same one-cycle delay.

Top module: `packed_lane_adder`

## Requirements
- R1: After reset, `valid_out` is 0, `sum_out` is all zeros and `ovf_out` is all zeros.
- R2: The lane size is set by `lane_mode`: 2'b00 gives eight 8-bit lanes, 2'b01 gives four 16-bit lanes, 2'b10 gives two 32-bit lanes and 2'b11 gives one 64-bit lane. Lane 0 occupies the least significant bits.
- R3: With `sat_en` = 0, each lane of `sum_out` holds (a_lane + b_lane) modulo 2^width. For example, 100 + 200 in a byte lane gives 44. No carry passes from one lane into the next.
- R4: With `sat_en` = 1, a lane whose unsigned sum overflows becomes all ones (100 + 200 in a byte lane gives 255). A lane that does not overflow holds its exact sum, whatever the neighbouring lanes do.
- R5: Bit k of `ovf_out` is set only when byte k is the top byte of a lane and that lane's unsigned sum overflowed. This holds in both wrap and saturating modes. All other bits are 0.
- R6: `valid_out` equals `valid_in` of the previous cycle. The result of an operation accepted with `valid_in` = 1 appears on `sum_out` and `ovf_out` on the next cycle.
- R7: While `valid_in` is 0, `sum_out` and `ovf_out` keep their values, even if the operands or controls change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operands and controls are valid this cycle |
| lane_mode | input | 2 | Lane size select (see R2) |
| sat_en | input | 1 | 1 = unsigned saturating, 0 = wraparound |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| valid_out | output | 1 | Registered result is valid |
| sum_out | output | 64 | Registered packed sum |
| ovf_out | output | 8 | Registered per-lane overflow flags, one at each lane's top byte |

## Verification
The bound checker checks these properties on every cycle:
- the one-cycle valid delay and the holding of results while idle;
- that no overflow flag appears outside a lane's top byte position;
- that a flagged lane under saturation reads all ones;
- the full 64-bit wrap sum.

Only the bench's sweeps can show the cut carry chain at each lane size. These sweeps check every lane size in both overflow modes, over broadcast byte corner values, carry-ripple patterns and pseudo-random operands, against an arithmetic model. They also confirm that one lane's saturation leaves its neighbours intact.

// File: rtl/packed_lane_adder.sv
module packed_lane_adder #(
  parameter int SEG_W  = 8,
  parameter int N_SEG  = 8,
  localparam int DATA_W = SEG_W * N_SEG,
  localparam int MODE_W = $clog2($clog2(N_SEG) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [MODE_W-1:0] lane_mode,
  input  logic              sat_en,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              valid_out,
  output logic [DATA_W-1:0] sum_out,
  output logic [N_SEG-1:0]  ovf_out
);

  logic [N_SEG-1:0]  span;
  logic [N_SEG-1:0]  cut, top, cout, lane_hit;
  logic [N_SEG:0]    cin;
  logic [DATA_W-1:0] sum_d;
  logic [N_SEG-1:0]  ovf_d;

  assign span = N_SEG'((1 << lane_mode) - 1);

  for (genvar i = 0; i < N_SEG; i++) begin : g_seg
    logic [SEG_W-1:0] part;

    assign cut[i] = (N_SEG'(i) & span) == '0;
    assign top[i] = (N_SEG'(i + 1) & span) == '0;

    if (i == 0) begin : g_lsb
      assign cin[i] = 1'b0;
    end else begin : g_mid
      assign cin[i] = cut[i] ? 1'b0 : cout[i-1];
    end

    assign {cout[i], part} = {1'b0, op_a[i*SEG_W +: SEG_W]}
                           + {1'b0, op_b[i*SEG_W +: SEG_W]}
                           + (SEG_W + 1)'(cin[i]);

    if (i == N_SEG - 1) begin : g_msb
      assign lane_hit[i] = cout[i];
    end else begin : g_low
      assign lane_hit[i] = top[i] ? cout[i] : lane_hit[i+1];
    end

    assign sum_d[i*SEG_W +: SEG_W] = (sat_en && lane_hit[i]) ? {SEG_W{1'b1}} : part;
    assign ovf_d[i] = top[i] & cout[i];
  end

  assign cin[N_SEG] = cout[N_SEG-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      sum_out   <= '0;
      ovf_out   <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        sum_out <= sum_d;
        ovf_out <= ovf_d;
      end
    end
  end

endmodule

module packed_lane_adder_chk #(
  parameter int SEG_W  = 8,
  parameter int N_SEG  = 8,
  localparam int DATA_W = SEG_W * N_SEG,
  localparam int MODE_W = $clog2($clog2(N_SEG) + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_in,
  input logic [MODE_W-1:0] lane_mode,
  input logic              sat_en,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              valid_out,
  input logic [DATA_W-1:0] sum_out,
  input logic [N_SEG-1:0]  ovf_out
);

  localparam logic [MODE_W-1:0] WIDEST = MODE_W'($clog2(N_SEG));

  logic [MODE_W-1:0] mode_q;
  logic              sat_q;
  logic [N_SEG-1:0]  top_q;
  logic              sat_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      sat_q  <= 1'b0;
    end else if (valid_in) begin
      mode_q <= lane_mode;
      sat_q  <= sat_en;
    end
  end

  always_comb begin
    logic [N_SEG-1:0] sp;
    logic             flag;
    sp = N_SEG'((1 << mode_q) - 1);
    for (int k = 0; k < N_SEG; k++) top_q[k] = (N_SEG'(k + 1) & sp) == '0;
    sat_bad = 1'b0;
    flag = 1'b0;
    for (int k = N_SEG - 1; k >= 0; k--) begin
      if (top_q[k]) flag = ovf_out[k];
      if (sat_q && flag && sum_out[k*SEG_W +: SEG_W] != {SEG_W{1'b1}}) sat_bad = 1'b1;
    end
  end

  a_r6_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  a_r6_valid_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(sum_out) && $stable(ovf_out)));
  a_r5_flag_position: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_out & ~top_q) == '0);
  a_r4_sat_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_bad);
  a_r3_full_width_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && lane_mode == WIDEST && !sat_en) |=> sum_out == $past(op_a + op_b));

endmodule

bind packed_lane_adder packed_lane_adder_chk #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_chk (.*);

// File: tb/packed_lane_adder_bench.sv
module packed_lane_adder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [1:0]  lane_mode = 2'b00;
  logic        sat_en = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        valid_out;
  logic [63:0] sum_out;
  logic [7:0]  ovf_out;

  int checks = 0;
  int fails = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  packed_lane_adder u_packed_lane_adder (.*);

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] m, input logic s,
                                output logic [63:0] r, output logic [7:0] f);
    int w;
    logic [64:0] mask, x, y, t;
    w = 8 << m;
    mask = (65'd1 << w) - 65'd1;
    r = '0;
    f = '0;
    for (int lo = 0; lo < 64; lo += w) begin
      x = ({1'b0, a} >> lo) & mask;
      y = ({1'b0, b} >> lo) & mask;
      t = x + y;
      if (t[w]) f[(lo + w) / 8 - 1] = 1'b1;
      t = (s && t[w]) ? mask : (t & mask);
      r = r | (t[63:0] << lo);
    end
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b,
                     input logic [1:0] m, input logic s, input string req);
    logic [63:0] er;
    logic [7:0]  ef;
    model(a, b, m, s, er, ef);
    @(negedge clk);
    op_a = a; op_b = b; lane_mode = m; sat_en = s; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    check(req, "sum", sum_out, er);
    check("R5", "ovf", {56'd0, ovf_out}, {56'd0, ef});
  endtask

  function automatic logic [63:0] next_rand();
    rng ^= rng << 13;
    rng ^= rng >> 7;
    rng ^= rng << 17;
    return rng;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] corner [6];
    logic [63:0] held_s;
    logic [7:0]  held_f;
    corner = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};

    repeat (3) @(negedge clk);
    check("R1", "valid", {63'd0, valid_out}, 64'd0);
    check("R1", "sum", sum_out, 64'd0);
    check("R1", "ovf", {56'd0, ovf_out}, 64'd0);
    rst_n = 1'b1;

    run({8{8'd100}}, {8{8'd200}}, 2'b00, 1'b0, "R3");
    run({8{8'd100}}, {8{8'd200}}, 2'b00, 1'b1, "R4");
    run(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 2'b00, 1'b0, "R2");
    run(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 2'b01, 1'b0, "R2");
    run(64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, 2'b10, 1'b0, "R2");
    run(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1'b0, "R2");
    run(64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 2'b10, 1'b1, "R4");
    run(64'h00FF_00FF_00FF_00FF, 64'h00FF_0001_0001_00FF, 2'b00, 1'b1, "R4");

    @(negedge clk);
    op_a = 64'h1234; op_b = 64'h1111; lane_mode = 2'b11; valid_in = 1'b1;
    #1 check("R6", "valid before edge", {63'd0, valid_out}, 64'd0);
    @(negedge clk);
    check("R6", "valid after edge", {63'd0, valid_out}, 64'd1);
    check("R6", "sum after edge", sum_out, 64'h2345);
    valid_in = 1'b0;
    held_s = sum_out;
    held_f = ovf_out;
    op_a = '1; op_b = '1; lane_mode = 2'b00; sat_en = 1'b1;
    @(negedge clk);
    check("R6", "valid drops", {63'd0, valid_out}, 64'd0);
    @(negedge clk);
    check("R7", "sum held", sum_out, held_s);
    check("R7", "ovf held", {56'd0, ovf_out}, {56'd0, held_f});

    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            run({8{corner[i]}}, {8{corner[j]}}, 2'(m), 1'(s), s ? "R4" : "R3");
        for (int k = 0; k < 64; k++) begin
          logic [63:0] ra, rb;
          ra = next_rand();
          rb = next_rand();
          if (k % 4 == 1) rb = ~ra;
          if (k % 4 == 2) rb = 64'd1 << (k % 64);
          if (k % 4 == 3) ra = ra | 64'h7F7F_7F7F_7F7F_7F7F;
          run(ra, rb, 2'(m), 1'(s), s ? "R4" : "R3");
        end
      end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule